// File: doc/BRIEF.md
# Coherent Port Burst Compliance Monitor

This passive monitor watches the address and data channels of an AXI-style master that feeds a cache-coherent port. It never drives a ready signal or changes a transfer. Each burst is sorted into one of two classes. Fast-path bursts are those whose shape the coherent port handles at full speed. Every other legal shape goes into the slow class. For writes, the monitor also catches a dangerous case: a burst has the fast shape, so the cache will treat it as a whole-line write, but some of its byte strobes are cleared. It also flags lock attributes that the coherent path cannot honour. After every transaction it emits a one-cycle report, and three saturating counters keep running totals for software-free debug probes.

A write goes through two named states. **WS_IDLE** waits for a write-address handshake. Transition *addr_accept* moves it to **WS_BEATS**, and it stays there while strobes are gathered from each accepted data beat. Transition *last_accept* is the handshake of the beat marked last. It returns to WS_IDLE and fires the report. While the monitor is in WS_BEATS, write-address handshakes are not tracked, so only one write can be outstanding. Reads need no state: each read-address handshake is reported on the next cycle.

Fast-path shape, with `cfg_narrow` = 0 (64-bit master):
- size 3 and length 3, meaning 4 beats;
- either a wrapping burst (type 2'b10) whose address bits [2:0] are all zero, or an incrementing burst (type 2'b01) whose address bits [1:0] are all zero.

With `cfg_narrow` = 1 (32-bit master), the fast-path shape is size 2 and length 7, meaning 8 beats, under the same burst-type and alignment rules.

Top module: `coh_burst_monitor`

## Requirements
- R1: With cfg_narrow=0, a wrapping burst of len 3 and size 3 at an address with bits [2:0]=0 is reported with pref=1, whether it is a read or a write whose strobes are all set.
- R2: With cfg_narrow=0, an incrementing burst of len 3 and size 3 at an address with bits [1:0]=0 is fast. The following are slow (pref=0): a wrapping burst whose address bits [2:0] are not zero, and an incrementing burst whose address bits [1:0] are not zero.
- R3: With cfg_narrow=1, the fast shape is len 7 and size 2 under the R1/R2 alignment rules. A len 3, size 3 burst is slow in this mode.
- R4: Any other length, size or burst type, including fixed (2'b00), is reported with pref=0. The burst is still reported, with done=1.
- R5: A write with the fast shape in which any accepted beat has a cleared strobe byte is reported with hazard=1 and pref=0. A write with a slow shape never raises hazard. With cfg_narrow=1, only strobe bits [3:0] are examined.
- R6: wr_done is high for exactly one cycle, in the cycle after the handshake of the beat with w_last=1. A beat is sampled only when w_valid and w_ready are both high. wr_pref, wr_hazard and wr_viol are zero whenever wr_done is low.
- R7: rd_done is high for one cycle, in the cycle after a read-address handshake. An address that is valid but not ready produces no report. rd_pref and rd_viol are zero whenever rd_done is low.
- R8: viol bit 0 is set when lock=2'b01 (exclusive) and the coherent attribute is 1. An exclusive access to non-coherent memory leaves this bit clear.
- R9: viol bit 1 is set for lock=2'b10 (locked), whatever the coherent attribute.
- R10: viol bit 2 is set for an exclusive access only when cfg_narrow=1 and (len+1)<<size exceeds 8 bytes. An exclusive access with cfg_narrow=0 never sets it.
- R11: cnt_pref, cnt_slow and cnt_hazard count pref, non-pref and hazard reports from both channels. They update in the cycle after a report. When both channels report in the same cycle, the count rises by 2. Each counter stops at all-ones.
- R12: When cnt_clear is high at a clock edge, all three counters are zero after that edge. Clear wins over a simultaneous increment.
- R13: After reset, every report output and every counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_narrow | input | 1 | 1 selects a 32-bit master, 0 a 64-bit master |
| cnt_clear | input | 1 | Synchronous counter clear |
| aw_valid | input | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| aw_addr | input | ADDR_W | Write start address |
| aw_len | input | 8 | Write beats minus one |
| aw_size | input | 3 | Write log2 bytes per beat |
| aw_burst | input | 2 | Write burst type |
| aw_lock | input | 2 | Write lock attribute |
| aw_coh | input | 1 | Write targets coherent memory |
| w_valid | input | 1 | Write data valid |
| w_ready | input | 1 | Write data ready |
| w_strb | input | DATA_W/8 | Write byte strobes |
| w_last | input | 1 | Last write beat |
| ar_valid | input | 1 | Read address valid |
| ar_ready | input | 1 | Read address ready |
| ar_addr | input | ADDR_W | Read start address |
| ar_len | input | 8 | Read beats minus one |
| ar_size | input | 3 | Read log2 bytes per beat |
| ar_burst | input | 2 | Read burst type |
| ar_lock | input | 2 | Read lock attribute |
| ar_coh | input | 1 | Read targets coherent memory |
| wr_done | output | 1 | Write report pulse |
| wr_pref | output | 1 | Write was fast-path |
| wr_hazard | output | 1 | Partial-strobe full-line hazard |
| wr_viol | output | 3 | Write attribute flags {split, locked, excl_coh} |
| rd_done | output | 1 | Read report pulse |
| rd_pref | output | 1 | Read was fast-path |
| rd_viol | output | 3 | Read attribute flags {split, locked, excl_coh} |
| cnt_pref | output | CNT_W | Fast-path burst count |
| cnt_slow | output | CNT_W | Slow burst count |
| cnt_hazard | output | CNT_W | Hazard count |

## Verification
A write report is due one clock edge after the handshake of its last beat. A read report is due one edge after its address handshake. The counters follow one edge later still. The bench changes inputs on falling edges and reads the reports at the falling edge right after the handshake edge. It reads the counters one falling edge after that. This holds for every transaction, including those with a stalled beat and those that end on both channels in the same cycle.

// File: rtl/cbm_pkg.sv
package cbm_pkg;

    localparam logic [1:0] BURST_INCR = 2'b01;
    localparam logic [1:0] BURST_WRAP = 2'b10;
    localparam logic [1:0] LOCK_EXCL  = 2'b01;

    typedef enum logic [0:0] {
        WS_IDLE,
        WS_BEATS
    } wr_state_e;

    typedef struct packed {
        logic split;
        logic locked;
        logic excl_coh;
    } viol_t;

endpackage

// File: rtl/cbm_shape.sv
module cbm_shape
    import cbm_pkg::*;
#(
    parameter int STRB_W     = 8,
    parameter int LINE_BEATS = 4
) (
    input  logic                        narrow,
    input  logic [$clog2(STRB_W)-1:0]   addr_lo,
    input  logic [7:0]                  len,
    input  logic [2:0]                  size,
    input  logic [1:0]                  burst,
    input  logic [1:0]                  lock,
    input  logic                        coh,
    output logic                        pref_shape,
    output viol_t                       viol
);

    localparam int WIDE_SIZE   = $clog2(STRB_W);
    localparam int NARROW_SIZE = WIDE_SIZE - 1;
    localparam int WIDE_LEN    = LINE_BEATS - 1;
    localparam int NARROW_LEN  = 2 * LINE_BEATS - 1;

    logic        size_ok;
    logic        len_ok;
    logic        wrap_ok;
    logic        incr_ok;
    logic [15:0] span;

    always_comb begin
        size_ok    = narrow ? (size == 3'(NARROW_SIZE)) : (size == 3'(WIDE_SIZE));
        len_ok     = narrow ? (len == 8'(NARROW_LEN)) : (len == 8'(WIDE_LEN));
        wrap_ok    = (burst == BURST_WRAP) && (addr_lo == '0);
        incr_ok    = (burst == BURST_INCR) && (addr_lo[NARROW_SIZE-1:0] == '0);
        pref_shape = size_ok && len_ok && (wrap_ok || incr_ok);

        span          = ({8'd0, len} + 16'd1) << size;
        viol.excl_coh = (lock == LOCK_EXCL) && coh;
        viol.locked   = lock[1];
        viol.split    = (lock == LOCK_EXCL) && narrow && (span > 16'(STRB_W));
    end

endmodule

// File: rtl/cbm_wr_track.sv
module cbm_wr_track
    import cbm_pkg::*;
#(
    parameter int STRB_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              narrow,
    input  logic              aw_hs,
    input  logic              shape_pref,
    input  viol_t             aw_viol,
    input  logic              w_hs,
    input  logic [STRB_W-1:0] w_strb,
    input  logic              w_last,
    output logic              done,
    output logic              pref,
    output logic              hazard,
    output viol_t             viol
);

    localparam int HALF = STRB_W / 2;

    wr_state_e state, state_nx;
    logic      shp_q;
    viol_t     vio_q;
    logic      strb_ok_q;
    logic      beat_full;
    logic      line_full;
    logic      last_hs;

    assign beat_full = narrow ? (&w_strb[HALF-1:0]) : (&w_strb);
    assign line_full = strb_ok_q && beat_full;
    assign last_hs   = (state == WS_BEATS) && w_hs && w_last;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= WS_IDLE;
        else        state <= state_nx;
    end

    // transitions: addr_accept, last_accept
    always_comb begin
        state_nx = state;
        unique case (state)
            WS_IDLE:  if (aw_hs)           state_nx = WS_BEATS;
            WS_BEATS: if (w_hs && w_last)  state_nx = WS_IDLE;
        endcase
    end

    // captured attributes and report outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shp_q     <= 1'b0;
            vio_q     <= '0;
            strb_ok_q <= 1'b0;
            done      <= 1'b0;
            pref      <= 1'b0;
            hazard    <= 1'b0;
            viol      <= '0;
        end else begin
            done   <= last_hs;
            pref   <= last_hs && shp_q && line_full;
            hazard <= last_hs && shp_q && !line_full;
            viol   <= last_hs ? vio_q : '0;
            if (state == WS_IDLE && aw_hs) begin
                shp_q     <= shape_pref;
                vio_q     <= aw_viol;
                strb_ok_q <= 1'b1;
            end else if (state == WS_BEATS && w_hs) begin
                strb_ok_q <= line_full;
            end
        end
    end

endmodule

// File: rtl/cbm_sat_cnt.sv
module cbm_sat_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [1:0]       inc,
    output logic [CNT_W-1:0] count
);

    logic [CNT_W:0] sum;

    assign sum = {1'b0, count} + (CNT_W+1)'(inc);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) count <= '0;
        else if (sum[CNT_W]) count <= '1;
        else                 count <= sum[CNT_W-1:0];
    end

endmodule

// File: rtl/coh_burst_monitor.sv
module coh_burst_monitor
    import cbm_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 64,
    parameter int LINE_BEATS = 4,
    parameter int CNT_W      = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_narrow,
    input  logic                  cnt_clear,
    input  logic                  aw_valid,
    input  logic                  aw_ready,
    input  logic [ADDR_W-1:0]     aw_addr,
    input  logic [7:0]            aw_len,
    input  logic [2:0]            aw_size,
    input  logic [1:0]            aw_burst,
    input  logic [1:0]            aw_lock,
    input  logic                  aw_coh,
    input  logic                  w_valid,
    input  logic                  w_ready,
    input  logic [DATA_W/8-1:0]   w_strb,
    input  logic                  w_last,
    input  logic                  ar_valid,
    input  logic                  ar_ready,
    input  logic [ADDR_W-1:0]     ar_addr,
    input  logic [7:0]            ar_len,
    input  logic [2:0]            ar_size,
    input  logic [1:0]            ar_burst,
    input  logic [1:0]            ar_lock,
    input  logic                  ar_coh,
    output logic                  wr_done,
    output logic                  wr_pref,
    output logic                  wr_hazard,
    output logic [2:0]            wr_viol,
    output logic                  rd_done,
    output logic                  rd_pref,
    output logic [2:0]            rd_viol,
    output logic [CNT_W-1:0]      cnt_pref,
    output logic [CNT_W-1:0]      cnt_slow,
    output logic [CNT_W-1:0]      cnt_hazard
);

    localparam int STRB_W = DATA_W / 8;
    localparam int LO_W   = $clog2(STRB_W);
    localparam int N_CNT  = 3;

    logic  aw_pref, ar_pref;
    viol_t aw_vio, ar_vio, wr_vio_s;
    logic  unused_addr_hi;

    assign unused_addr_hi = ^{aw_addr[ADDR_W-1:LO_W], ar_addr[ADDR_W-1:LO_W]};

    cbm_shape #(.STRB_W(STRB_W), .LINE_BEATS(LINE_BEATS)) u_aw_shape (
        .narrow(cfg_narrow), .addr_lo(aw_addr[LO_W-1:0]), .len(aw_len),
        .size(aw_size), .burst(aw_burst), .lock(aw_lock), .coh(aw_coh),
        .pref_shape(aw_pref), .viol(aw_vio)
    );

    cbm_shape #(.STRB_W(STRB_W), .LINE_BEATS(LINE_BEATS)) u_ar_shape (
        .narrow(cfg_narrow), .addr_lo(ar_addr[LO_W-1:0]), .len(ar_len),
        .size(ar_size), .burst(ar_burst), .lock(ar_lock), .coh(ar_coh),
        .pref_shape(ar_pref), .viol(ar_vio)
    );

    cbm_wr_track #(.STRB_W(STRB_W)) u_wr (
        .clk(clk), .rst_n(rst_n), .narrow(cfg_narrow),
        .aw_hs(aw_valid && aw_ready), .shape_pref(aw_pref), .aw_viol(aw_vio),
        .w_hs(w_valid && w_ready), .w_strb(w_strb), .w_last(w_last),
        .done(wr_done), .pref(wr_pref), .hazard(wr_hazard), .viol(wr_vio_s)
    );

    assign wr_viol = wr_vio_s;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_done <= 1'b0;
            rd_pref <= 1'b0;
            rd_viol <= '0;
        end else begin
            rd_done <= ar_valid && ar_ready;
            rd_pref <= ar_valid && ar_ready && ar_pref;
            rd_viol <= (ar_valid && ar_ready) ? ar_vio : '0;
        end
    end

    logic [1:0]       cnt_inc [N_CNT];
    logic [CNT_W-1:0] cnt_val [N_CNT];

    assign cnt_inc[0] = {1'b0, wr_pref} + {1'b0, rd_pref};
    assign cnt_inc[1] = {1'b0, wr_done && !wr_pref} + {1'b0, rd_done && !rd_pref};
    assign cnt_inc[2] = {1'b0, wr_hazard};

    for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
        cbm_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .clear(cnt_clear),
            .inc(cnt_inc[i]), .count(cnt_val[i])
        );
    end

    assign cnt_pref   = cnt_val[0];
    assign cnt_slow   = cnt_val[1];
    assign cnt_hazard = cnt_val[2];

endmodule

// File: rtl/cbm_checker.sv
module cbm_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_clear,
    input logic             ar_valid,
    input logic             ar_ready,
    input logic             wr_done,
    input logic             wr_pref,
    input logic             wr_hazard,
    input logic [2:0]       wr_viol,
    input logic             rd_done,
    input logic             rd_pref,
    input logic [2:0]       rd_viol,
    input logic [CNT_W-1:0] cnt_pref,
    input logic [CNT_W-1:0] cnt_slow,
    input logic [CNT_W-1:0] cnt_hazard
);

    AST_WR_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> !wr_done);                                              // R6
    AST_WR_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_done |-> (!wr_pref && !wr_hazard && wr_viol == 3'b000));        // R6
    AST_PREF_EXCLUDES_HAZARD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_pref && wr_hazard));                                           // R5
    AST_RD_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> $past(ar_valid && ar_ready));                           // R7
    AST_RD_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_done |-> (!rd_pref && rd_viol == 3'b000));                      // R7
    AST_PREF_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clear |=> cnt_pref >= $past(cnt_pref));                        // R11
    AST_HAZ_WITHIN_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_hazard <= cnt_slow);                                            // R11
    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clear |=> (cnt_pref == '0 && cnt_slow == '0 && cnt_hazard == '0)); // R12

endmodule

bind coh_burst_monitor cbm_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cnt_clear(cnt_clear),
    .ar_valid(ar_valid), .ar_ready(ar_ready),
    .wr_done(wr_done), .wr_pref(wr_pref), .wr_hazard(wr_hazard), .wr_viol(wr_viol),
    .rd_done(rd_done), .rd_pref(rd_pref), .rd_viol(rd_viol),
    .cnt_pref(cnt_pref), .cnt_slow(cnt_slow), .cnt_hazard(cnt_hazard)
);

// File: tb/tb_coh_burst_monitor.sv
module tb_coh_burst_monitor;

    typedef struct packed {
        logic        narrow;
        logic        wr;
        logic [11:0] addr;
        logic [7:0]  len;
        logic [2:0]  size;
        logic [1:0]  burst;
        logic [1:0]  lock;
        logic        coh;
        logic [3:0]  bad;    // beat with partial strobe, 15 = none
        logic        pref;
        logic        haz;
        logic [2:0]  viol;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 12'h100, 8'd3, 3'd3, 2'b10, 2'b00, 1'b0, 4'd15, 1'b1, 1'b0, 3'b000, 4'd1},  // R1
        '{1'b0, 1'b0, 12'h100, 8'd3, 3'd3, 2'b10, 2'b00, 1'b0, 4'd15, 1'b1, 1'b0, 3'b000, 4'd1},  // R1
        '{1'b0, 1'b1, 12'h104, 8'd3, 3'd3, 2'b01, 2'b00, 1'b0, 4'd15, 1'b1, 1'b0, 3'b000, 4'd2},  // R2
        '{1'b0, 1'b0, 12'h104, 8'd3, 3'd3, 2'b10, 2'b00, 1'b0, 4'd15, 1'b0, 1'b0, 3'b000, 4'd2},  // R2
        '{1'b0, 1'b0, 12'h102, 8'd3, 3'd3, 2'b01, 2'b00, 1'b0, 4'd15, 1'b0, 1'b0, 3'b000, 4'd2},  // R2
        '{1'b1, 1'b1, 12'h204, 8'd7, 3'd2, 2'b01, 2'b00, 1'b0, 4'd15, 1'b1, 1'b0, 3'b000, 4'd3},  // R3
        '{1'b1, 1'b0, 12'h208, 8'd7, 3'd2, 2'b10, 2'b00, 1'b0, 4'd15, 1'b1, 1'b0, 3'b000, 4'd3},  // R3
        '{1'b1, 1'b0, 12'h200, 8'd3, 3'd3, 2'b01, 2'b00, 1'b0, 4'd15, 1'b0, 1'b0, 3'b000, 4'd3},  // R3
        '{1'b0, 1'b0, 12'h000, 8'd7, 3'd3, 2'b01, 2'b00, 1'b0, 4'd15, 1'b0, 1'b0, 3'b000, 4'd4},  // R4
        '{1'b0, 1'b1, 12'h100, 8'd3, 3'd3, 2'b00, 2'b00, 1'b0, 4'd15, 1'b0, 1'b0, 3'b000, 4'd4},  // R4
        '{1'b0, 1'b1, 12'h100, 8'd3, 3'd3, 2'b10, 2'b00, 1'b0, 4'd2,  1'b0, 1'b1, 3'b000, 4'd5},  // R5
        '{1'b0, 1'b1, 12'h100, 8'd1, 3'd3, 2'b01, 2'b00, 1'b0, 4'd0,  1'b0, 1'b0, 3'b000, 4'd5},  // R5
        '{1'b1, 1'b1, 12'h204, 8'd7, 3'd2, 2'b01, 2'b00, 1'b0, 4'd5,  1'b0, 1'b1, 3'b000, 4'd5},  // R5
        '{1'b0, 1'b0, 12'h100, 8'd3, 3'd3, 2'b10, 2'b01, 1'b1, 4'd15, 1'b1, 1'b0, 3'b001, 4'd8},  // R8
        '{1'b0, 1'b1, 12'h100, 8'd0, 3'd3, 2'b01, 2'b01, 1'b0, 4'd15, 1'b0, 1'b0, 3'b000, 4'd8},  // R8
        '{1'b0, 1'b0, 12'h100, 8'd0, 3'd3, 2'b01, 2'b10, 1'b0, 4'd15, 1'b0, 1'b0, 3'b010, 4'd9},  // R9
        '{1'b1, 1'b1, 12'h100, 8'd3, 3'd2, 2'b01, 2'b01, 1'b0, 4'd15, 1'b0, 1'b0, 3'b100, 4'd10}, // R10
        '{1'b1, 1'b0, 12'h100, 8'd1, 3'd2, 2'b01, 2'b01, 1'b1, 4'd15, 1'b0, 1'b0, 3'b001, 4'd10}, // R10
        '{1'b0, 1'b1, 12'h100, 8'd3, 3'd3, 2'b01, 2'b01, 1'b0, 4'd15, 1'b1, 1'b0, 3'b000, 4'd10}  // R10
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_narrow = 1'b0, cnt_clear = 1'b0;
    logic        aw_valid = 1'b0, aw_ready = 1'b0, aw_coh = 1'b0;
    logic [31:0] aw_addr = '0, ar_addr = '0;
    logic [7:0]  aw_len = '0, ar_len = '0;
    logic [2:0]  aw_size = '0, ar_size = '0;
    logic [1:0]  aw_burst = '0, ar_burst = '0, aw_lock = '0, ar_lock = '0;
    logic        w_valid = 1'b0, w_ready = 1'b0, w_last = 1'b0;
    logic [7:0]  w_strb = '0;
    logic        ar_valid = 1'b0, ar_ready = 1'b0, ar_coh = 1'b0;

    logic        wr_done, wr_pref, wr_hazard, rd_done, rd_pref;
    logic [2:0]  wr_viol, rd_viol;
    logic [15:0] cnt_pref, cnt_slow, cnt_hazard;

    logic        s_wr_done, s_wr_pref, s_wr_hazard, s_rd_done, s_rd_pref;
    logic [2:0]  s_wr_viol, s_rd_viol;
    logic [1:0]  s_cnt_pref, s_cnt_slow, s_cnt_hazard;

    int n_chk = 0;
    int n_fail = 0;
    int exp_pref = 0, exp_slow = 0, exp_haz = 0;

    always #10 clk = ~clk;

    coh_burst_monitor dut (
        .clk(clk), .rst_n(rst_n), .cfg_narrow(cfg_narrow), .cnt_clear(cnt_clear),
        .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr), .aw_len(aw_len),
        .aw_size(aw_size), .aw_burst(aw_burst), .aw_lock(aw_lock), .aw_coh(aw_coh),
        .w_valid(w_valid), .w_ready(w_ready), .w_strb(w_strb), .w_last(w_last),
        .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr), .ar_len(ar_len),
        .ar_size(ar_size), .ar_burst(ar_burst), .ar_lock(ar_lock), .ar_coh(ar_coh),
        .wr_done(wr_done), .wr_pref(wr_pref), .wr_hazard(wr_hazard), .wr_viol(wr_viol),
        .rd_done(rd_done), .rd_pref(rd_pref), .rd_viol(rd_viol),
        .cnt_pref(cnt_pref), .cnt_slow(cnt_slow), .cnt_hazard(cnt_hazard)
    );

    coh_burst_monitor #(.CNT_W(2)) dut_sat (
        .clk(clk), .rst_n(rst_n), .cfg_narrow(cfg_narrow), .cnt_clear(cnt_clear),
        .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr), .aw_len(aw_len),
        .aw_size(aw_size), .aw_burst(aw_burst), .aw_lock(aw_lock), .aw_coh(aw_coh),
        .w_valid(w_valid), .w_ready(w_ready), .w_strb(w_strb), .w_last(w_last),
        .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr), .ar_len(ar_len),
        .ar_size(ar_size), .ar_burst(ar_burst), .ar_lock(ar_lock), .ar_coh(ar_coh),
        .wr_done(s_wr_done), .wr_pref(s_wr_pref), .wr_hazard(s_wr_hazard), .wr_viol(s_wr_viol),
        .rd_done(s_rd_done), .rd_pref(s_rd_pref), .rd_viol(s_rd_viol),
        .cnt_pref(s_cnt_pref), .cnt_slow(s_cnt_slow), .cnt_hazard(s_cnt_hazard)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    task automatic run_vec(input vec_t v);
        logic [5:0] act, exp;
        logic [7:0] good, badv;
        good = v.narrow ? 8'h0F : 8'hFF;
        badv = v.narrow ? 8'hF7 : 8'h7F;
        @(negedge clk);
        cfg_narrow = v.narrow;
        if (v.wr) begin
            aw_addr = {20'd0, v.addr}; aw_len = v.len; aw_size = v.size;
            aw_burst = v.burst; aw_lock = v.lock; aw_coh = v.coh;
            aw_valid = 1'b1; aw_ready = 1'b1;
            @(negedge clk);
            aw_valid = 1'b0; aw_ready = 1'b0;
            for (int b = 0; b <= int'(v.len); b++) begin
                if (b == 1) begin
                    // stalled beat with empty strobes must not be sampled (R6)
                    w_valid = 1'b1; w_ready = 1'b0; w_strb = 8'h00;
                    w_last = (b == int'(v.len));
                    @(negedge clk);
                end
                w_valid = 1'b1; w_ready = 1'b1;
                w_strb = (b == int'(v.bad)) ? badv : good;
                w_last = (b == int'(v.len));
                @(negedge clk);
            end
            w_valid = 1'b0; w_ready = 1'b0; w_last = 1'b0;
            act = {wr_done, wr_pref, wr_hazard, wr_viol};
        end else begin
            ar_addr = {20'd0, v.addr}; ar_len = v.len; ar_size = v.size;
            ar_burst = v.burst; ar_lock = v.lock; ar_coh = v.coh;
            ar_valid = 1'b1; ar_ready = 1'b0;
            @(negedge clk);
            check(rd_done == 1'b0, "R7 stall", {31'd0, rd_done}, 32'd0);
            ar_ready = 1'b1;
            @(negedge clk);
            ar_valid = 1'b0; ar_ready = 1'b0;
            act = {rd_done, rd_pref, 1'b0, rd_viol};
        end
        exp = {1'b1, v.pref, v.haz, v.viol};
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d vector actual=%0h expected=%0h", v.req, act, exp);
        end
        if (v.pref) exp_pref++; else exp_slow++;
        if (v.haz) exp_haz++;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13: reset state
        check({wr_done, wr_pref, wr_hazard, wr_viol, rd_done, rd_pref, rd_viol} == '0,
              "R13 reports", {20'd0, wr_done, wr_pref, wr_hazard, wr_viol, rd_done, rd_pref, rd_viol}, 32'd0);
        check({cnt_pref, cnt_slow, cnt_hazard} == '0, "R13 counters",
              {16'd0, cnt_pref}, 32'd0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        @(negedge clk);
        // R11: totals after all vectors
        check(cnt_pref == 16'(exp_pref), "R11 pref count", {16'd0, cnt_pref}, exp_pref);
        check(cnt_slow == 16'(exp_slow), "R11 slow count", {16'd0, cnt_slow}, exp_slow);
        check(cnt_hazard == 16'(exp_haz), "R11 hazard count", {16'd0, cnt_hazard}, exp_haz);
        // R11: 2-bit counters stop at all-ones
        check(s_cnt_pref == 2'd3, "R11 saturate pref", {30'd0, s_cnt_pref}, 32'd3);
        check(s_cnt_slow == 2'd3, "R11 saturate slow", {30'd0, s_cnt_slow}, 32'd3);
        check(s_cnt_hazard == 2'd2, "R11 hazard below max", {30'd0, s_cnt_hazard}, 32'd2);

        // R12: clear
        cnt_clear = 1'b1;
        @(negedge clk);
        cnt_clear = 1'b0;
        check({cnt_pref, cnt_slow, cnt_hazard} == '0, "R12 clear",
              {16'd0, cnt_pref | cnt_slow | cnt_hazard}, 32'd0);

        // R11: both channels report in the same cycle
        cfg_narrow = 1'b0;
        aw_addr = 32'h100; aw_len = 8'd3; aw_size = 3'd3; aw_burst = 2'b10;
        aw_lock = 2'b00; aw_coh = 1'b0; aw_valid = 1'b1; aw_ready = 1'b1;
        @(negedge clk);
        aw_valid = 1'b0; aw_ready = 1'b0;
        for (int b = 0; b < 4; b++) begin
            w_valid = 1'b1; w_ready = 1'b1; w_strb = 8'hFF; w_last = (b == 3);
            if (b == 3) begin
                ar_addr = 32'h100; ar_len = 8'd3; ar_size = 3'd3; ar_burst = 2'b10;
                ar_lock = 2'b00; ar_coh = 1'b0; ar_valid = 1'b1; ar_ready = 1'b1;
            end
            @(negedge clk);
        end
        w_valid = 1'b0; w_ready = 1'b0; w_last = 1'b0; ar_valid = 1'b0; ar_ready = 1'b0;
        check(wr_done && wr_pref && rd_done && rd_pref, "R1 concurrent reports",
              {28'd0, wr_done, wr_pref, rd_done, rd_pref}, 32'hF);
        @(negedge clk);
        check(cnt_pref == 16'd2, "R11 double increment", {16'd0, cnt_pref}, 32'd2);
        check(wr_done == 1'b0, "R6 single pulse", {31'd0, wr_done}, 32'd0);

        finish_run();
    end

endmodule